// File: doc/BRIEF.md
# Pipelined Four-Element Sorter

This block sorts a bundle of four unsigned values into ascending order. It accepts one bundle per clock, marked by a valid bit. The bundle passes through a three-register compare-and-swap network and comes out three cycles later with its own valid bit. Lane 0 of the output carries the smallest value and lane 3 the largest.

A new bundle may enter on every cycle, so the unit runs at full throughput. Cycles with the valid bit low travel through the pipeline as bubbles and leave the bundles around them unchanged. There is no flow control. When the output valid is low, the output data carries no meaning. The element width is a parameter, with a default of 8 bits.

Top module: `quad_sorter`

## Requirements
- R1: When `out_valid` is high, `out_data` is in ascending unsigned order. Lane k occupies bits [k*ELEM_W +: ELEM_W], and lane 0 holds the smallest value.
- R2: An accepted bundle (`in_valid` high at a rising edge) raises `out_valid` at the third rising edge after that one, with the sorted data. `out_valid` does not rise at any earlier edge.
- R3: Bundles presented on consecutive cycles leave on consecutive cycles, in the order they entered, with no gaps.
- R4: The output is a permutation of the input and keeps duplicates. For example, {2,8,2,8} gives {2,2,8,8} and {1,1,1,1} gives {1,1,1,1}.
- R5: A cycle with `in_valid` low gives a cycle with `out_valid` low three cycles later. The bundles on either side of it still come out correctly sorted.
- R6: The reset is synchronous and active low (`rst_n` low at a rising edge). It clears every stage valid bit, so `out_valid` is low after that edge and bundles already in flight are dropped.
- R7: Comparisons are unsigned. A value with its top bit set, such as 0xFF or 0x80, sorts above 0x7F and 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input bundle valid |
| in_data | input | 4 x ELEM_W | Four input lanes, lane k at [k*ELEM_W +: ELEM_W] |
| out_valid | output | 1 | Output bundle valid |
| out_data | output | 4 x ELEM_W | Sorted lanes, lane 0 smallest |

## Verification
Each result, a sorted bundle or a bubble, is due three rising edges after the edge that captured its input. No output changes earlier than that. The bench drives inputs on falling edges. In the table walk it checks the output on the falling edge three iterations after the vector was driven, which is half a cycle after the third capturing edge. The directed latency test checks `out_valid` at the first, second, third and fourth falling edge after a single bundle. The reset test checks `out_valid` on the falling edge right after the reset edge and on the three falling edges that follow, which is when the dropped bundles would otherwise have come out.

// File: rtl/quad_sorter_pkg.sv
// Shared constants for the four-lane sorter.
// Assumes a fixed lane count of four, which the comparator schedule relies on.
package quad_sorter_pkg;
    localparam int LANES = 4;
    localparam int DEPTH = 3;
endpackage

// File: rtl/qs_cmp_swap.sv
// Combinational compare-and-swap: emits the lower and the higher of two
// unsigned values. Assumes equal values may leave in either order.
module qs_cmp_swap #(
    parameter int ELEM_W = 8
) (
    input  logic [ELEM_W-1:0] a,
    input  logic [ELEM_W-1:0] b,
    output logic [ELEM_W-1:0] lo,
    output logic [ELEM_W-1:0] hi
);
    // Pick the order of the pair by an unsigned compare.
    always_comb begin
        if (a <= b) begin
            lo = a;
            hi = b;
        end else begin
            lo = b;
            hi = a;
        end
    end
endmodule

// File: rtl/qs_stage.sv
// One register stage of the sorting network. STAGE picks the comparators:
// stage 1 orders lanes (0,1) and (2,3), stage 2 orders (0,2) and (1,3),
// stage 3 orders (1,2) and passes lanes 0 and 3 through.
// Assumes four lanes. Only the valid bit is reset; the data is left as it is.
module qs_stage
    import quad_sorter_pkg::*;
#(
    parameter int ELEM_W = 8,
    parameter int STAGE  = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [LANES-1:0][ELEM_W-1:0]  in_lanes,
    output logic                          out_valid,
    output logic [LANES-1:0][ELEM_W-1:0]  out_lanes
);
    logic [LANES-1:0][ELEM_W-1:0] nxt;

    generate
        if (STAGE == 3) begin : g_mid
            localparam int LO_I = 1;
            localparam int HI_I = 2;
            // Middle pair only; the outer lanes already hold the extremes.
            qs_cmp_swap #(.ELEM_W(ELEM_W)) u_cs (
                .a (in_lanes[LO_I]), .b (in_lanes[HI_I]),
                .lo(nxt[LO_I]),      .hi(nxt[HI_I])
            );
            assign nxt[0] = in_lanes[0];
            assign nxt[3] = in_lanes[3];
        end else begin : g_two
            localparam int A_LO = 0;
            localparam int A_HI = (STAGE == 1) ? 1 : 2;
            localparam int B_LO = (STAGE == 1) ? 2 : 1;
            localparam int B_HI = 3;
            qs_cmp_swap #(.ELEM_W(ELEM_W)) u_cs_a (
                .a (in_lanes[A_LO]), .b (in_lanes[A_HI]),
                .lo(nxt[A_LO]),      .hi(nxt[A_HI])
            );
            qs_cmp_swap #(.ELEM_W(ELEM_W)) u_cs_b (
                .a (in_lanes[B_LO]), .b (in_lanes[B_HI]),
                .lo(nxt[B_LO]),      .hi(nxt[B_HI])
            );
        end
    endgenerate

    // Track the bundle valid bit, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Capture the partly ordered lanes every cycle.
    always_ff @(posedge clk) begin
        out_lanes <= nxt;
    end
endmodule

// File: rtl/quad_sorter.sv
// Pipelined four-lane ascending sorter: three chained network stages, one
// bundle per cycle, fixed latency of DEPTH cycles. Assumes no backpressure.
module quad_sorter
    import quad_sorter_pkg::*;
#(
    parameter int ELEM_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [LANES-1:0][ELEM_W-1:0]  in_data,
    output logic                          out_valid,
    output logic [LANES-1:0][ELEM_W-1:0]  out_data
);
    logic [DEPTH:0]                         v_chain;
    logic [DEPTH:0][LANES-1:0][ELEM_W-1:0]  d_chain;

    assign v_chain[0] = in_valid;
    assign d_chain[0] = in_data;

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            qs_stage #(.ELEM_W(ELEM_W), .STAGE(s + 1)) u_stage (
                .clk      (clk),
                .rst_n    (rst_n),
                .in_valid (v_chain[s]),
                .in_lanes (d_chain[s]),
                .out_valid(v_chain[s+1]),
                .out_lanes(d_chain[s+1])
            );
        end
    endgenerate

    assign out_valid = v_chain[DEPTH];
    assign out_data  = d_chain[DEPTH];
endmodule

// File: rtl/quad_sorter_chk.sv
// Property checker for quad_sorter, bound to every instance of it.
// Assumes the sorter's port names and a fixed three-cycle latency.
module quad_sorter_chk
    import quad_sorter_pkg::*;
#(
    parameter int ELEM_W = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic [LANES-1:0][ELEM_W-1:0]  in_data,
    input logic                          out_valid,
    input logic [LANES-1:0][ELEM_W-1:0]  out_data
);
    localparam int SUM_W = ELEM_W + 2;

    logic [SUM_W-1:0]  in_sum, out_sum;
    logic [ELEM_W-1:0] in_min;

    // Reference sum and minimum of the input bundle.
    always_comb begin
        in_sum  = '0;
        out_sum = '0;
        in_min  = in_data[0];
        for (int k = 0; k < LANES; k++) begin
            in_sum  = in_sum + SUM_W'(in_data[k]);
            out_sum = out_sum + SUM_W'(out_data[k]);
            if (in_data[k] < in_min) in_min = in_data[k];
        end
    end

    p_ascending_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data[0] <= out_data[1]) && (out_data[1] <= out_data[2])
                      && (out_data[2] <= out_data[3]));

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);

    p_keeps_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_sum == $past(in_sum, 3));

    p_keeps_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_data[0] == $past(in_min, 3));

    p_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##3 !out_valid);

    p_reset_clears_r6: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

bind quad_sorter quad_sorter_chk #(.ELEM_W(ELEM_W)) u_chk (.*);

// File: tb/quad_sorter_bench.sv
// Self-checking bench for quad_sorter: a vector table walked at full rate,
// then directed tests for latency and mid-stream reset.
module quad_sorter_bench;
    localparam int W  = 8;
    localparam int NV = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [3:0][W-1:0] in_data = '0;
    logic              out_valid;
    logic [3:0][W-1:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Lane 0 is the low byte; expected values list lane 3 first.
    localparam logic        T_VLD [NV] = '{1, 1, 1, 0, 1, 1, 1, 1, 0, 1};
    localparam logic [31:0] T_IN  [NV] = '{
        32'h01030204, 32'h08020802, 32'h01010101, 32'hFFFFFFFF, 32'h7F8001FF,
        32'h01070609, 32'hFF00FF00, 32'h04030201, 32'h00000000, 32'h09000804};
    localparam logic [31:0] T_EXP [NV] = '{
        32'h04030201, 32'h08080202, 32'h01010101, 32'h00000000, 32'hFF807F01,
        32'h09070601, 32'hFFFF0000, 32'h04030201, 32'h00000000, 32'h09080400};

    quad_sorter #(.ELEM_W(W)) u_quad_sorter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #5 clk = ~clk;

    task automatic check_v(input logic exp, input string tag);
        n_chk++;
        if (out_valid !== exp) begin
            n_bad++;
            $display("FAIL %s: out_valid=%0b expected %0b", tag, out_valid, exp);
        end
    endtask

    task automatic check_d(input logic [31:0] exp, input string tag);
        n_chk++;
        if (out_data !== exp) begin
            n_bad++;
            $display("FAIL %s: out_data=%h expected %h", tag, out_data, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        // Reset state.
        repeat (3) @(negedge clk);
        check_v(1'b0, "R6 reset state");
        rst_n = 1'b1;

        // Table walk: one vector per cycle, result due three iterations later.
        for (int i = 0; i < NV + 3; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                check_v(T_VLD[i-3], (T_VLD[i-3] ? "R2 R3 valid" : "R5 bubble"));
                if (T_VLD[i-3]) check_d(T_EXP[i-3], "R1 R3 R4 R7 order");
            end
            in_valid = (i < NV) ? T_VLD[i] : 1'b0;
            in_data  = (i < NV) ? T_IN[i] : '0;
        end

        // Directed latency: one bundle, then bubbles.
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 32'h80017F02;
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = '0;
        check_v(1'b0, "R2 edge 1");
        @(negedge clk);
        check_v(1'b0, "R2 edge 2");
        @(negedge clk);
        check_v(1'b1, "R2 edge 3");
        check_d(32'h807F0201, "R2 R7 data");
        @(negedge clk);
        check_v(1'b0, "R2 edge 4");

        // Mid-stream reset drops bundles in flight.
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 32'h11223344;
        end
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_v(1'b0, "R6 after reset edge");
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            check_v(1'b0, "R6 flushed");
        end

        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            finish_run();
        end
    end
endmodule